// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave

This block is the slave side of a two-wire serial memory whose clock and data lines are toggled by a software-driven master. Both lines enter through synchronisers in a free-running system clock domain. The slave acts only on pin changes. It spots start and stop conditions and counts accepted bits through a command byte and then an address byte. It pulls the data line low for acknowledge slots. When the command's least significant bit requests a read, it presents a stored byte most significant bit first on the same clock edges that carry the address.

The array holds 2^ADDR_W bytes, 256 by default. After reset, byte i holds (i * FILL_MUL + FILL_ADD) mod 256. A write port can overwrite any byte while the line is idle. The byte presented during a read is the one fetched at the end of the previous transaction. The end of each address phase reloads the output register from the addressed location. The master reads back the bus level as the wired-AND of its own drive and the slave's release.

Top module: `bitbang_eeprom_slave`

## Requirements
- R1: After reset, sda_pull_low is 0 and sda_seen is 1.
- R2: While the bit counter is idle and no acknowledge is pending, clock edges are ignored: sda_pull_low stays 0 and sda_seen follows the master's SDA.
- R3: SDA falling while SCL stays high is a start: the counter restarts at the first command bit and the command register clears, even in the middle of a transaction.
- R4: SDA rising while SCL stays high is a stop. It does not move the counter, so bits sent after it continue the interrupted byte.
- R5: A bit is taken on an SCL rising edge only if SDA equals its last sampled level. An edge whose SDA changes in the same step is discarded and counts nothing.
- R6: Once eight command bits are taken, the next SCL rising edge is an acknowledge: sda_pull_low is 1 and sda_seen is 0, no bit is consumed, and the slave releases on the next pin change.
- R7: The eight bits taken after the command acknowledge form the address, first bit in the MSB. If command bit 0 is 1, the k-th of these edges (k = 0..7) presents bit 7-k of the output register: sda_pull_low is the inverse of that bit.
- R8: After the eighth address bit, the output register loads the addressed byte, the next rising edge is an acknowledge, and the counter returns to idle.
- R9: After reset, byte i of the array holds (i * FILL_MUL + FILL_ADD) mod 256, and the output register holds 0.
- R10: A cycle with init_we high writes init_data into byte init_addr.
- R11: sda_seen is the master's SDA AND the slave's release, and sda_pull_low is 1 only when the slave presents a 0.
- R12: Both outputs hold their value for as long as neither synchronised pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, free running |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Clock line level from the master |
| sda_in | input | 1 | Data line level driven by the master (1 = released) |
| init_we | input | 1 | Array write strobe |
| init_addr | input | ADDR_W | Array write address |
| init_data | input | DATA_W | Array write data |
| sda_pull_low | output | 1 | Slave pulls the data line low |
| sda_seen | output | 1 | Data line level as the master observes it |

## Verification
Bit capture and condition detection can be triggered by the same synchronised sample. This happens when SCL rises in the same step as SDA changes. The bench provokes it by moving both pins at once in the middle of a command byte, and checks that neither a bit nor a condition is recorded. The acknowledge must fall exactly after eight clean bits, and the byte read afterwards must match the command that was sent. Stops and restarts are also placed partway through a command byte, and acknowledge placement is checked after each.

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;
  // width of the device command byte shifted in before the address
  localparam int CMD_BITS = 8;
  // synchroniser depth for the two line inputs
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/eeslv_rst_sync.sv
module eeslv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign srst_n = chain_q[1];
endmodule

// File: rtl/eeslv_sync.sv
module eeslv_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL}};
      else        stg_q <= {stg_q[STAGES-2:0], d[b]};
    end
    assign q[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/eeslv_store.sv
module eeslv_store #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int FILL_MUL = 29,
  parameter int FILL_ADD = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  function automatic logic [DATA_W-1:0] fill_val(input int unsigned idx);
    return DATA_W'(idx * FILL_MUL + FILL_ADD);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= fill_val(i);
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eeslv_proto.sv
module eeslv_proto #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              pull_low,
  output logic              sda_seen
);
  localparam int CMD_W    = eeslv_pkg::CMD_BITS;
  localparam int CMD_END  = CMD_W + 1;
  localparam int ADDR_END = CMD_END + ADDR_W;
  localparam int TICK_W   = $clog2(ADDR_END + 1);
  localparam logic [TICK_W-1:0] T_ONE      = TICK_W'(1);
  localparam logic [TICK_W-1:0] T_CMD_END  = TICK_W'(CMD_END);
  localparam logic [TICK_W-1:0] T_ADDR_END = TICK_W'(ADDR_END);

  logic              scl_m, sda_m;     // previous synchronised master pins
  logic              lvl_q, lvl_n;     // last sampled/driven line level
  logic              pull_q, pull_n;
  logic              ack_q, ack_n;
  logic [TICK_W-1:0] tick_q, tick_n;
  logic [CMD_W-1:0]  cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              upd, is_rise, is_cond, drv_bit;

  assign upd     = (scl_s != scl_m) || (sda_s != sda_m);
  assign is_rise = !scl_m && scl_s;
  assign is_cond = scl_m && scl_s && (lvl_q != sda_s);
  assign drv_bit = data_q[DATA_W-1];

  always_comb begin
    tick_n = tick_q;
    cmd_n  = cmd_q;
    addr_n = addr_q;
    data_n = data_q;
    ack_n  = ack_q;
    lvl_n  = sda_s;
    pull_n = 1'b0;
    if (is_cond) begin
      if (!sda_s) begin
        tick_n = T_ONE;
        cmd_n  = '0;
      end
    end else if (tick_q == '0 && !ack_q) begin
      // idle until a start
    end else if (is_rise) begin
      if (ack_q) begin
        lvl_n  = 1'b0;
        pull_n = 1'b1;
        ack_n  = 1'b0;
      end else if (lvl_q == sda_s) begin
        if (tick_q < T_CMD_END) begin
          cmd_n  = {cmd_q[CMD_W-2:0], sda_s};
          tick_n = tick_q + T_ONE;
          if (tick_n == T_CMD_END) ack_n = 1'b1;
        end else if (tick_q < T_ADDR_END) begin
          if (cmd_q[0]) begin
            pull_n = !drv_bit;
            lvl_n  = sda_s & drv_bit;
          end
          addr_n = {addr_q[ADDR_W-2:0], sda_s};
          data_n = data_q << 1;
          tick_n = tick_q + T_ONE;
          if (tick_n == T_ADDR_END) begin
            data_n = rd_data;
            ack_n  = 1'b1;
            tick_n = '0;
          end
        end else begin
          lvl_n  = 1'b0;
          pull_n = 1'b1;
        end
      end
    end
  end

  assign rd_addr = addr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m  <= 1'b1;
      sda_m  <= 1'b1;
      lvl_q  <= 1'b1;
      pull_q <= 1'b0;
      ack_q  <= 1'b0;
      tick_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      scl_m <= scl_s;
      sda_m <= sda_s;
      if (upd) begin
        lvl_q  <= lvl_n;
        pull_q <= pull_n;
        ack_q  <= ack_n;
        tick_q <= tick_n;
        cmd_q  <= cmd_n;
        addr_q <= addr_n;
        data_q <= data_n;
      end
    end
  end

  assign pull_low = pull_q;
  assign sda_seen = lvl_q;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !is_cond && tick_q == '0 && !ack_q) |=> (tick_q == '0 && !pull_q));
  // R3
  start_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_cond && !sda_s) |=> (tick_q == T_ONE && cmd_q == '0));
  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_rise && ack_q) |=> (!ack_q && pull_q));
  // R8
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < T_ADDR_END);
  // R11
  pull_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> !lvl_q);
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(pull_q) && $stable(lvl_q) && $stable(tick_q)));
endmodule

// File: rtl/bitbang_eeprom_slave.sv
module bitbang_eeprom_slave #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int FILL_MUL = 29,
  parameter int FILL_ADD = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [DATA_W-1:0] init_data,
  output logic              sda_pull_low,
  output logic              sda_seen
);
  logic              srst_n;
  logic [1:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  eeslv_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  eeslv_sync #(
    .WIDTH   (2),
    .STAGES  (eeslv_pkg::SYNC_DEPTH),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     ({scl_in, sda_in}),
    .q     (pins_s)
  );

  eeslv_store #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FILL_MUL (FILL_MUL),
    .FILL_ADD (FILL_ADD)
  ) u_store (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (init_we),
    .wr_addr (init_addr),
    .wr_data (init_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  eeslv_proto #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_proto (
    .clk      (clk),
    .rst_n    (srst_n),
    .scl_s    (pins_s[1]),
    .sda_s    (pins_s[0]),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pull_low (sda_pull_low),
    .sda_seen (sda_seen)
  );
endmodule

// File: tb/sim_bitbang_eeprom_slave.sv
`timescale 1ns/1ps
module sim_bitbang_eeprom_slave;
  localparam int FMUL = 29;
  localparam int FADD = 90;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       init_we = 1'b0;
  logic [7:0] init_addr = '0;
  logic [7:0] init_data = '0;
  logic       sda_pull_low, sda_seen;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mem_m [256];
  logic [7:0] prev_data;

  always #2.5 clk = ~clk;

  bitbang_eeprom_slave #(.ADDR_W(8), .DATA_W(8), .FILL_MUL(FMUL), .FILL_ADD(FADD)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .sda_pull_low(sda_pull_low), .sda_seen(sda_seen)
  );

  function automatic logic [7:0] fill_ref(input int i);
    return 8'((i * FMUL + FADD) % 256);
  endfunction

  task automatic chk(input string tag, input logic ep, input logic es);
    n_chk++;
    if (sda_pull_low !== ep || sda_seen !== es) begin
      n_bad++;
      $display("FAIL %s pull=%0b exp %0b seen=%0b exp %0b", tag, sda_pull_low, ep, sda_seen, es);
    end
  endtask

  task automatic put(input logic c, input logic d);
    @(negedge clk);
    scl_in = c;
    sda_in = d;
    repeat (8) @(negedge clk);
  endtask

  task automatic bit_edge(input logic b, input logic ep, input logic es, input string tag);
    put(1'b0, b);
    put(1'b1, b);
    chk(tag, ep, es);
  endtask

  task automatic ack_edge(input string tag);
    put(1'b0, 1'b1);
    put(1'b1, 1'b1);
    chk(tag, 1'b1, 1'b0);
    put(1'b0, 1'b1);
    chk(tag, 1'b0, 1'b1);
  endtask

  task automatic start_cond();
    put(1'b1, 1'b0);
    chk("R3 start", 1'b0, 1'b0);
    put(1'b0, 1'b0);
  endtask

  task automatic stop_cond();
    put(1'b0, 1'b0);
    put(1'b1, 1'b0);
    put(1'b1, 1'b1);
    chk("R8 idle after stop", 1'b0, 1'b1);
  endtask

  task automatic cmd_bits(input logic [7:0] cmd, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) bit_edge(cmd[i], 1'b0, cmd[i], "R3 command bit");
  endtask

  task automatic send_addr(input logic [7:0] cmd, input logic [7:0] addr, input string tag);
    for (int i = 7; i >= 0; i--) begin
      logic ab, db;
      ab = addr[i];
      db = prev_data[i];
      if (cmd[0]) bit_edge(ab, !db, ab & db, tag);
      else        bit_edge(ab, 1'b0, ab, tag);
    end
    prev_data = mem_m[addr];
    ack_edge("R8 address ack");
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [7:0] addr, input string tag);
    start_cond();
    cmd_bits(cmd, 7, 0);
    ack_edge("R6 command ack");
    send_addr(cmd, addr, tag);
    stop_cond();
  endtask

  task automatic mem_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    init_we = 1'b1; init_addr = a; init_data = d;
    @(negedge clk);
    init_we = 1'b0;
    mem_m[a] = d;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem_m[i] = fill_ref(i);
    prev_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 reset", 1'b0, 1'b1);

    // R2: edges with no start are ignored
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = 1'($urandom);
      bit_edge(b, 1'b0, b, "R2 idle edge");
    end
    bit_edge(1'b1, 1'b0, 1'b1, "R2 idle edge");

    // R9: first read presents reset output register (0), then byte 0x00 default
    txn(8'hA1, 8'h00, "R9 R7 initial data");
    txn(8'hA1, 8'hFF, "R9 R7 default fill");
    txn(8'hA1, 8'h3C, "R9 R7 default fill");

    // R12: acknowledge level held while pins stay still
    start_cond();
    cmd_bits(8'hA1, 7, 0);
    put(1'b0, 1'b1);
    put(1'b1, 1'b1);
    chk("R6 ack", 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk("R12 hold", 1'b1, 1'b0);
    put(1'b0, 1'b1);
    chk("R6 release", 1'b0, 1'b1);
    send_addr(8'hA1, 8'hFF, "R7 read");
    stop_cond();

    // R10: init port overwrite
    mem_write(8'h5D, 8'hC3);
    txn(8'hA0, 8'h5D, "R7 write cmd");
    txn(8'hA1, 8'hFF, "R10 overwritten byte");

    // R4: stop inside the command byte does not restart counting
    start_cond();
    cmd_bits(8'hA1, 7, 4);
    put(1'b1, 1'b1);
    chk("R4 stop", 1'b0, 1'b1);
    cmd_bits(8'hA1, 3, 0);
    ack_edge("R4 ack after eight bits");
    send_addr(8'hA1, 8'h11, "R4 read continues");
    stop_cond();

    // R5: SCL rise with SDA change is discarded
    start_cond();
    cmd_bits(8'hA1, 7, 6);
    put(1'b0, 1'b0);
    put(1'b1, 1'b1);
    chk("R5 discarded edge", 1'b0, 1'b1);
    for (int i = 5; i >= 0; i--) bit_edge(8'hA1 >> i, 1'b0, 1'((8'hA1 >> i) & 1), "R5 good bit");
    ack_edge("R5 ack after eight good bits");
    send_addr(8'hA1, 8'hFF, "R5 command intact");
    stop_cond();

    // R3: restart in the middle of a command byte
    start_cond();
    cmd_bits(8'hE0, 7, 5);
    start_cond();
    cmd_bits(8'hA1, 7, 0);
    ack_edge("R3 ack after restart");
    send_addr(8'hA1, 8'hFF, "R3 read after restart");
    stop_cond();

    // random transactions
    for (int t = 0; t < 24; t++) begin
      logic [7:0] c, a;
      if (($urandom % 3) == 0) mem_write(8'($urandom), 8'($urandom));
      c = {7'b1010000, 1'($urandom)};
      a = 8'($urandom);
      if (c[0]) txn(c, a, "R7 R11 random read");
      else      txn(c, a, "R7 random write cmd");
    end
    txn(8'hA1, 8'h00, "R7 R11 final read");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule